// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running clock/calendar and raises alarms. It holds two independent alarm slots. Each slot carries a target second, minute, hour (with a PM bit), date, month and day of week. Each of those six fields has its own enable bit. On every one-second tick the current time is compared with each slot. A slot hits when at least one of its fields is enabled and every enabled field equals the current value.

A hit sets a sticky status flag for that slot. The host polls the flag and clears it with a strobe. Fields left disabled act as wildcards. For example, enabling only the seconds and minutes field makes the alarm repeat once an hour.

Each slot also has an interrupt-enable bit. An active-low interrupt level is driven while any flag is set whose interrupt enable is on. The year is not compared. In 12-hour mode the PM bit takes part in the hour comparison; in 24-hour mode it does not.

Top module: `alm_match`

## Requirements
- R1: After reset both status flags read 0 and `irq_n_o` is 1.
- R2: Each slot is a 42-bit word at `alm_cfg_i[k*42 +: 42]`, laid out LSB first as follows. Seconds are in [6:0] and minutes in [13:7], both BCD. Hour is in [19:14] (BCD) and the PM bit is in [20]. Date is in [26:21], month in [31:27] and day of week in [34:32]. The field enables sit in [40:35], in the order seconds, minutes, hour, date, month, day of week, starting at bit 35. The interrupt enable is bit [41]. When `tick_i` is high in a cycle and every enabled field of slot k equals the current time inputs, `flag_o[k]` reads 1 from the next cycle. A mismatch in any enabled field sets nothing.
- R3: A field whose enable bit is 0 is ignored. A slot with only the seconds field enabled fires whenever the seconds match, whatever the minutes, hours, date, month and day of week are.
- R4: A slot with all six field enables at 0 never sets its flag.
- R5: The comparison is taken only in cycles where `tick_i` is 1. A matching time with `tick_i` low leaves the flag at 0.
- R6: A flag stays set until `clr_i[k]` is pulsed, and a non-matching tick does not clear it. A clear pulse with no hit clears the flag in the next cycle. A hit in the same cycle as a clear leaves the flag set.
- R7: `irq_n_o` is 0 exactly while some slot has its flag at 1 and its interrupt-enable bit [41] at 1. Otherwise it is 1.
- R8: With `mode12_i` = 1, the hour field matches only if both the hour value and the PM bit are equal. With `mode12_i` = 0, the PM bits are ignored.
- R9: The two slots are independent. A hit or a clear on one slot leaves the other slot's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second tick; the time inputs are already updated in this cycle |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hour, BCD |
| cur_pm_i | input | 1 | Current PM bit (12-hour mode) |
| cur_date_i | input | 6 | Current date, BCD |
| cur_month_i | input | 5 | Current month, BCD |
| cur_dow_i | input | 3 | Current day of week |
| mode12_i | input | 1 | 1 selects 12-hour format |
| alm_cfg_i | input | 84 | Two alarm slot words, 42 bits each |
| clr_i | input | 2 | Per-slot flag clear strobe |
| flag_o | output | 2 | Per-slot sticky alarm status |
| irq_n_o | output | 1 | Active-low interrupt level |

## Verification
The comparison is tried with several patterns:
- An exact match on all fields, which shows that a hit sets the flag.
- A single mismatched enabled field, which shows that any enabled field can veto the hit.
- A seconds-only enable with every other field different, which shows that disabled fields act as wildcards.
- All enables off against an identical time, which separates "no fields" from "all match".
- A matching time held with no tick, which shows that the tick gates the comparison.

The hour is tried with differing PM bits in both formats, which separates 12-hour from 24-hour comparison. Set, clear and their same-cycle overlap are driven on one slot while the other is observed, which separates sticky hold, clear priority and cross-slot leakage.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HR_W   = 6;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int DOW_W  = 3;
  localparam int NFLD   = 6;
  localparam int TIME_W = SEC_W + MIN_W + HR_W + 1 + DATE_W + MON_W + DOW_W;
  localparam int CFG_W  = TIME_W + NFLD + 1;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;
  localparam int F_DOW  = 5;

  typedef struct packed {
    logic [DOW_W-1:0]  dow;
    logic [MON_W-1:0]  mon;
    logic [DATE_W-1:0] date;
    logic              pm;
    logic [HR_W-1:0]   hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } time_t;

  typedef struct packed {
    logic            ie;
    logic [NFLD-1:0] en;
    time_t           t;
  } cfg_t;

  // Per-field equality; hour includes PM only in 12-hour mode.
  function automatic logic [NFLD-1:0] field_eq(time_t a, time_t b, logic mode12);
    logic [NFLD-1:0] e;
    e[F_SEC]  = (a.sec  == b.sec);
    e[F_MIN]  = (a.min  == b.min);
    e[F_HR]   = (a.hour == b.hour) && (!mode12 || (a.pm == b.pm));
    e[F_DATE] = (a.date == b.date);
    e[F_MON]  = (a.mon  == b.mon);
    e[F_DOW]  = (a.dow  == b.dow);
    return e;
  endfunction

  // Hit when at least one field enabled and all enabled fields equal.
  function automatic logic alarm_hit(logic [NFLD-1:0] eq, logic [NFLD-1:0] en);
    return (|en) && (&(eq | ~en));
  endfunction
endpackage

// File: rtl/alm_cmp.sv
module alm_cmp
  import alm_pkg::*;
(
  input  time_t cur_i,
  input  cfg_t  cfg_i,
  input  logic  mode12_i,
  output logic  match_o
);
  logic [NFLD-1:0] eq_w;

  always_comb begin
    eq_w    = field_eq(cur_i, cfg_i.t, mode12_i);
    match_o = alarm_hit(eq_w, cfg_i.en);
  end
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  a_r2_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic [6:0]                  cur_sec_i,
  input  logic [6:0]                  cur_min_i,
  input  logic [5:0]                  cur_hour_i,
  input  logic                        cur_pm_i,
  input  logic [5:0]                  cur_date_i,
  input  logic [4:0]                  cur_month_i,
  input  logic [2:0]                  cur_dow_i,
  input  logic                        mode12_i,
  input  logic [NUM_ALARMS*CFG_W-1:0] alm_cfg_i,
  input  logic [NUM_ALARMS-1:0]       clr_i,
  output logic [NUM_ALARMS-1:0]       flag_o,
  output logic                        irq_n_o
);
  time_t                 cur_w;
  logic [NUM_ALARMS-1:0] match_w;
  logic [NUM_ALARMS-1:0] hit_w;
  logic [NUM_ALARMS-1:0] ie_w;

  assign cur_w = '{dow: cur_dow_i, mon: cur_month_i, date: cur_date_i,
                   pm: cur_pm_i, hour: cur_hour_i, min: cur_min_i, sec: cur_sec_i};

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_slot
    cfg_t cfg_w;
    assign cfg_w    = alm_cfg_i[k*CFG_W +: CFG_W];
    assign ie_w[k]  = cfg_w.ie;
    assign hit_w[k] = tick_i & match_w[k];

    alm_cmp u_cmp (
      .cur_i    (cur_w),
      .cfg_i    (cfg_w),
      .mode12_i (mode12_i),
      .match_o  (match_w[k])
    );

    alm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit_w[k]),
      .clr_i  (clr_i[k]),
      .flag_o (flag_o[k])
    );

    a_r4_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && (cfg_w.en == '0) && !flag_o[k] |=> !flag_o[k]);
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !flag_o[k] |=> !flag_o[k]);
    a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[k] && cfg_w.ie |-> !irq_n_o);
  end

  assign irq_n_o = ~|(flag_o & ie_w);

  a_r1_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (flag_o == '0) && irq_n_o);
  a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_o & ie_w) == '0) |-> irq_n_o);
endmodule

// File: tb/tb_alm_match.sv
module tb_alm_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [6:0]  sec = '0, mins = '0;
  logic [5:0]  hour = '0, date = '0;
  logic        pm = 1'b0, mode12 = 1'b0;
  logic [4:0]  mon = '0;
  logic [2:0]  dow = '0;
  logic [41:0] cfg0 = '0, cfg1 = '0;
  logic [1:0]  clr = '0;
  logic [1:0]  flag;
  logic        irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alm_match dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cur_sec_i(sec), .cur_min_i(mins), .cur_hour_i(hour), .cur_pm_i(pm),
    .cur_date_i(date), .cur_month_i(mon), .cur_dow_i(dow), .mode12_i(mode12),
    .alm_cfg_i({cfg1, cfg0}), .clr_i(clr), .flag_o(flag), .irq_n_o(irq_n)
  );

  function automatic logic [41:0] mk(logic [6:0] s, logic [6:0] m, logic [5:0] h,
                                     logic p, logic [5:0] d, logic [4:0] mo,
                                     logic [2:0] w, logic [5:0] en, logic ie);
    return {ie, en, w, mo, d, p, h, m, s};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_time(logic [6:0] s, logic [6:0] m, logic [5:0] h, logic p,
                          logic [5:0] d, logic [4:0] mo, logic [2:0] w);
    @(negedge clk);
    sec = s; mins = m; hour = h; pm = p; date = d; mon = mo; dow = w;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_clr(logic [1:0] m);
    @(negedge clk) clr = m;
    @(negedge clk) clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", {6'd0, flag}, 8'd0);
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_full_match();
    cfg0 = mk(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3, 6'h3F, 0);
    cfg1 = mk(7'h10, 7'h10, 6'h10, 0, 6'h10, 5'h10, 3'd1, 6'h3F, 0);
    set_time(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3);
    pulse_tick();
    chk("R2 full match flag0", {7'd0, flag[0]}, 8'd1);
    chk("R9 other slot idle", {7'd0, flag[1]}, 8'd0);
    chk("R7 ie off irq_n", {7'd0, irq_n}, 8'd1);
    pulse_clr(2'b01);
    set_time(7'h45, 7'h31, 6'h12, 0, 6'h15, 5'h06, 3'd3);
    pulse_tick();
    chk("R2 minute mismatch", {7'd0, flag[0]}, 8'd0);
    set_time(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd4);
    pulse_tick();
    chk("R2 dow mismatch", {7'd0, flag[0]}, 8'd0);
  endtask

  task automatic t_partial();
    cfg0 = mk(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3, 6'h01, 0);
    set_time(7'h45, 7'h59, 6'h03, 1, 6'h01, 5'h11, 3'd6);
    pulse_tick();
    chk("R3 seconds-only wildcard", {7'd0, flag[0]}, 8'd1);
    pulse_clr(2'b01);
    chk("R6 cleared", {7'd0, flag[0]}, 8'd0);
  endtask

  task automatic t_noen();
    cfg0 = mk(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3, 6'h00, 1);
    set_time(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3);
    pulse_tick();
    chk("R4 no enables", {7'd0, flag[0]}, 8'd0);
    chk("R4 irq_n", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_notick();
    cfg0 = mk(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3, 6'h3F, 0);
    set_time(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3);
    repeat (5) @(negedge clk);
    chk("R5 no tick", {7'd0, flag[0]}, 8'd0);
  endtask

  task automatic t_sticky();
    pulse_tick();
    chk("R6 set", {7'd0, flag[0]}, 8'd1);
    set_time(7'h00, 7'h00, 6'h00, 0, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R6 held over mismatch tick", {7'd0, flag[0]}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R6 held idle", {7'd0, flag[0]}, 8'd1);
    pulse_clr(2'b01);
    chk("R6 clear", {7'd0, flag[0]}, 8'd0);
    set_time(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3);
    @(negedge clk) begin tick = 1'b1; clr = 2'b01; end
    @(negedge clk) begin tick = 1'b0; clr = 2'b00; end
    chk("R6 hit beats clear", {7'd0, flag[0]}, 8'd1);
    pulse_clr(2'b01);
  endtask

  task automatic t_irq();
    cfg0 = mk(7'h45, 7'h30, 6'h12, 0, 6'h15, 5'h06, 3'd3, 6'h3F, 1);
    @(negedge clk);
    chk("R7 irq idle", {7'd0, irq_n}, 8'd1);
    pulse_tick();
    chk("R7 irq low", {7'd0, irq_n}, 8'd0);
    pulse_clr(2'b01);
    chk("R7 irq released", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_12h();
    mode12 = 1'b1;
    cfg0 = mk(7'h00, 7'h00, 6'h11, 1, 6'h01, 5'h01, 3'd0, 6'h04, 0);
    set_time(7'h00, 7'h00, 6'h11, 0, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R8 12h AM vs PM", {7'd0, flag[0]}, 8'd0);
    set_time(7'h00, 7'h00, 6'h11, 1, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R8 12h PM match", {7'd0, flag[0]}, 8'd1);
    pulse_clr(2'b01);
    mode12 = 1'b0;
    set_time(7'h00, 7'h00, 6'h11, 0, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R8 24h pm ignored", {7'd0, flag[0]}, 8'd1);
    pulse_clr(2'b01);
  endtask

  task automatic t_indep();
    cfg0 = mk(7'h05, 7'h00, 6'h00, 0, 6'h01, 5'h01, 3'd0, 6'h01, 0);
    cfg1 = mk(7'h20, 7'h00, 6'h00, 0, 6'h01, 5'h01, 3'd0, 6'h01, 1);
    set_time(7'h20, 7'h00, 6'h00, 0, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R9 slot1 only", {6'd0, flag}, 8'd2);
    chk("R7 slot1 irq", {7'd0, irq_n}, 8'd0);
    set_time(7'h05, 7'h00, 6'h00, 0, 6'h01, 5'h01, 3'd0);
    pulse_tick();
    chk("R9 both set", {6'd0, flag}, 8'd3);
    pulse_clr(2'b10);
    chk("R9 clear slot1 only", {6'd0, flag}, 8'd1);
    chk("R7 slot0 ie off", {7'd0, irq_n}, 8'd1);
    pulse_clr(2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_match();
    t_partial();
    t_noen();
    t_notick();
    t_sticky();
    t_irq();
    t_12h();
    t_indep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule